// File: doc/BRIEF.md
# Byte-at-a-time I2C Master

This block is an I2C bus master that software drives one byte at a time through two byte-wide registers. Software first puts a byte in the data register. It then writes a command byte to the control register. The command says whether the byte goes out or comes in, whether a START comes before it, whether a STOP comes after it, and, on a read, whether the master acknowledges the byte. The controller then runs the bus for that byte and its acknowledge slot. While it does so, the busy bit reads as 1.

Once busy reads 0, software reads the acknowledge level sampled on the bus and, after a read, the received byte. A transaction is built from a sequence of commands:
- a START plus the address byte,
- register or data bytes,
- an optional repeated START with a read address,
- reads with ACK,
- a last read with NACK plus STOP.

Both bus lines are open-drain. An output enable pulls the line low, and the line level comes back through a synchronised input. A slave that holds SCL low stretches the high phase of the clock.

Top module: `i2c_byte_master`

## Requirements
- R1: Offset 0 (addr=0) is the data register. Offset 1 (addr=1) is the control register. Control reads back as {bit7 busy, bit6 0, bit5 ack-select, bit4 ack-status, bit3 0, bit2 stop, bit1 start, bit0 direction}, where the lower fields are those of the last accepted command. After reset both registers read 0 and both output enables are 0.
- R2: A control write with bit 7 = 1 while idle launches a byte operation, and busy reads 1 until that operation has finished. A control write with bit 7 = 0 starts nothing and changes no field.
- R3: With direction bit 0 = 0, the data register byte goes out MSB first on 8 SCL pulses. SDA is then released for a ninth, acknowledge, pulse.
- R4: With direction bit 0 = 1, the master releases SDA for 8 pulses and samples the bits MSB first while SCL is high. The byte is readable in the data register once busy reads 0.
- R5: With bit 1 = 1, the byte is preceded by a START, that is, SDA falls while SCL is high. This works from an idle bus and also, as a repeated START, from a bus left with SCL held low.
- R6: With bit 2 = 1, the acknowledge pulse is followed by a STOP, that is, SDA rises while SCL is high, leaving both lines released. Without bit 2 the byte ends with SCL held low and SDA released.
- R7: On a read, bit 5 = 1 makes the master drive SDA low (ACK) in the acknowledge slot, and bit 5 = 0 leaves SDA high (NACK). On a write, bit 5 has no effect on the bus.
- R8: Control bit 4 reads the SDA level sampled in the last acknowledge slot: 0 means the byte was acknowledged, 1 means it was not. It changes only while an operation runs.
- R9: Control bit 6 is ignored. Commands that differ only in bit 6 give identical bus activity, and bit 6 always reads 0.
- R10: Writes to either register while busy is 1 are ignored.
- R11: SDA changes only while SCL is low, except at the START and STOP conditions.
- R12: While the master has released SCL but the line reads low, the clock phase does not advance. A slave holding SCL low therefore extends the operation without corrupting the byte.
- R13: Every SCL high phase and every SCL low phase lasts at least 2*QDIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 data, 1 control |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data of the register selected by addr |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
The bench attaches a behavioural slave to the wired-AND lines and goes after several corner cases:
- A repeated START from a held-low SCL. A design that left SDA low, or raised SCL first, would show no START.
- Chained reads with ACK followed by a NACK+STOP read. Swapping the ACK sense would make the slave keep driving and block the STOP.
- Commands issued while busy. A design that accepted them would change the readback fields or add a STOP.
- A slave that stretches SCL for hundreds of cycles. A design that ignored the stretch would shift in wrong bits or finish early.
- Counts of START and STOP conditions, and minimum phase lengths, across a seeded random mix of reads and writes. Any SDA change while SCL is high, or a short clock phase, shows up there.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

   // Control register bit positions (software decodes these)
   localparam int CB_DIR   = 0;
   localparam int CB_START = 1;
   localparam int CB_STOP  = 2;
   localparam int CB_STAT  = 4;
   localparam int CB_ACK   = 5;
   localparam int CB_GO    = 7;

   localparam int BYTE_W   = 8;
   localparam int SLOT_CNT = BYTE_W + 1;   // data bits plus acknowledge slot

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_START,
      ENG_BIT,
      ENG_STOP,
      ENG_TAIL
   } eng_st_t;

   typedef struct packed {
      logic ack;
      logic stop;
      logic start;
      logic dir;
   } cmd_t;

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("i2cb_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b1;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '1;
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end

endmodule

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
   parameter int QDIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic hold,
   output logic tick
);

   localparam int CW = (QDIV <= 2) ? 1 : $clog2(QDIV);
   localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

   if (QDIV < 2) begin : g_bad_div
      $error("i2cb_qtick: QDIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!en)         cnt <= '0;
      else if (!hold)       cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign tick = en && !hold && (cnt == LAST);

   AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hold) |=> $stable(cnt));  // R12

endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
   import i2cb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        go,
   input  cmd_t        cmd_in,
   input  logic [7:0]  tx_byte,
   input  logic        sda_s,
   output logic        scl_oe,
   output logic        sda_oe,
   output logic        busy,
   output logic        done,
   output logic        ack_lvl,
   output logic [7:0]  rx_byte
);

   localparam logic [3:0] ACK_SLOT = 4'(SLOT_CNT - 1);

   eng_st_t     st;
   logic [1:0]  q;
   logic [3:0]  bitcnt;
   logic        c_dir, c_stop, c_ack;
   logic [7:0]  sh;
   logic        bit_drive;

   always_comb begin
      if (bitcnt < ACK_SLOT) bit_drive = !c_dir && !sh[7];
      else                   bit_drive = c_dir && c_ack;
   end

   assign busy    = (st != ENG_IDLE);
   assign done    = tick && (q == 2'd3) && ((st == ENG_STOP) || (st == ENG_TAIL));
   assign rx_byte = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ENG_IDLE;
         q       <= '0;
         bitcnt  <= '0;
         c_dir   <= 1'b0;
         c_stop  <= 1'b0;
         c_ack   <= 1'b0;
         sh      <= '0;
         scl_oe  <= 1'b0;
         sda_oe  <= 1'b0;
         ack_lvl <= 1'b0;
      end else if (st == ENG_IDLE) begin
         if (go) begin
            c_dir  <= cmd_in.dir;
            c_stop <= cmd_in.stop;
            c_ack  <= cmd_in.ack;
            sh     <= tx_byte;
            q      <= '0;
            bitcnt <= '0;
            st     <= cmd_in.start ? ENG_START : ENG_BIT;
         end
      end else if (tick) begin
         q <= q + 2'd1;
         unique case (st)
            ENG_START: begin
               unique case (q)
                  2'd0: sda_oe <= 1'b0;            // release SDA (SCL low or idle)
                  2'd1: scl_oe <= 1'b0;            // release SCL
                  2'd2: sda_oe <= 1'b1;            // START: SDA falls, SCL high
                  default: begin
                     scl_oe <= 1'b1;
                     st     <= ENG_BIT;
                  end
               endcase
            end
            ENG_BIT: begin
               unique case (q)
                  2'd0: scl_oe <= 1'b1;
                  2'd1: sda_oe <= bit_drive;
                  2'd2: scl_oe <= 1'b0;
                  default: begin
                     if (bitcnt == ACK_SLOT) begin
                        ack_lvl <= sda_s;
                        bitcnt  <= '0;
                        st      <= c_stop ? ENG_STOP : ENG_TAIL;
                     end else begin
                        sh     <= {sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               endcase
            end
            ENG_STOP: begin
               unique case (q)
                  2'd0: scl_oe <= 1'b1;
                  2'd1: sda_oe <= 1'b1;
                  2'd2: scl_oe <= 1'b0;
                  default: begin
                     sda_oe <= 1'b0;               // STOP: SDA rises, SCL high
                     st     <= ENG_IDLE;
                  end
               endcase
            end
            ENG_TAIL: begin
               unique case (q)
                  2'd0: scl_oe <= 1'b1;
                  2'd1: sda_oe <= 1'b0;
                  2'd2: ;
                  default: st <= ENG_IDLE;
               endcase
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(scl_oe)) |->
         (($rose(sda_oe) && $past(st) == ENG_START) ||
          ($fell(sda_oe) && $past(st) == ENG_STOP)));  // R11

   AST_SLOT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (bitcnt <= ACK_SLOT));  // R3

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ENG_IDLE && st == ENG_IDLE) |-> ($stable(scl_oe) && $stable(sda_oe)));  // R6

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cb_pkg::*;
#(
   parameter int QDIV        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       scl_oe,
   input  logic       scl_in,
   output logic       sda_oe,
   input  logic       sda_in
);

   logic       scl_s, sda_s;
   logic       busy, eng_done, eng_ack, tick, hold, go;
   logic [7:0] data_q, rx_byte;
   cmd_t       cmd_q, cmd_new;

   i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

   i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   assign hold = busy && !scl_oe && !scl_s;

   i2cb_qtick #(.QDIV(QDIV)) u_qtick (
      .clk(clk), .rst_n(rst_n), .en(busy), .hold(hold), .tick(tick));

   always_comb begin
      cmd_new.ack   = wdata[CB_ACK];
      cmd_new.stop  = wdata[CB_STOP];
      cmd_new.start = wdata[CB_START];
      cmd_new.dir   = wdata[CB_DIR];
   end

   assign go = wr_en && addr && wdata[CB_GO] && !busy;

   i2cb_engine u_engine (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .cmd_in(cmd_new),
      .tx_byte(data_q), .sda_s(sda_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .busy(busy), .done(eng_done), .ack_lvl(eng_ack), .rx_byte(rx_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cmd_q  <= '0;
      end else begin
         if (eng_done && cmd_q.dir)          data_q <= rx_byte;
         else if (wr_en && !addr && !busy)   data_q <= wdata;
         if (go)                             cmd_q  <= cmd_new;
      end
   end

   always_comb begin
      if (addr) begin
         rdata          = '0;
         rdata[CB_GO]   = busy;
         rdata[CB_ACK]  = cmd_q.ack;
         rdata[CB_STAT] = eng_ack;
         rdata[CB_STOP] = cmd_q.stop;
         rdata[CB_START]= cmd_q.start;
         rdata[CB_DIR]  = cmd_q.dir;
      end else begin
         rdata = data_q;
      end
   end

   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> $stable(cmd_q));  // R10

   AST_STATUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(eng_ack) |-> $past(busy));  // R8

   AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !busy);  // R2

   AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> busy);  // R2

endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
   localparam int QDIV = 4;
   localparam int STRETCH = 300;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0, rdata;
   logic scl_oe, sda_oe, scl_line, sda_line;
   logic slv_scl_low = 1'b0, slv_sda_low = 1'b0;

   assign scl_line = !(scl_oe || slv_scl_low);
   assign sda_line = !(sda_oe || slv_sda_low);

   i2c_byte_master #(.QDIV(QDIV), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line));

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // ---- behavioural slave and bus monitor ----
   logic       prev_scl = 1'b1, prev_sda = 1'b1;
   int         k = 0, byte_no = 0, tx_idx = 0, starts = 0, stops = 0;
   bit         tx_mode = 0, slv_ack = 1, master_ack = 0;
   logic [7:0] sh = '0, last_rx = '0;
   logic [7:0] slv_mem [0:7];
   bit         stretch_arm = 0;
   int         stretch_k = 3, stretch_cnt = 0;
   int         run_len = 0, min_hi = 1000000, min_lo = 1000000;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_scl = 1'b1; prev_sda = 1'b1; k = 0; tx_mode = 0;
      end else begin
         if (stretch_cnt > 0) begin
            stretch_cnt--;
            if (stretch_cnt == 0) slv_scl_low = 1'b0;
         end
         if (scl_line && prev_scl && sda_line != prev_sda) begin
            if (!sda_line) begin
               starts++; k = 0; byte_no = 0; tx_mode = 0; tx_idx = 0; slv_sda_low = 1'b0;
            end else begin
               stops++; tx_mode = 0; slv_sda_low = 1'b0;
            end
         end
         if (scl_line && !prev_scl) begin
            if (k < 8) sh = {sh[6:0], sda_line};
            else begin
               if (tx_mode) begin
                  master_ack = sda_line;
                  tx_idx++;
                  if (sda_line) tx_mode = 0;
               end else begin
                  last_rx = sh;
                  if (byte_no == 0 && sh[0] && slv_ack) tx_mode = 1;
               end
               byte_no++;
            end
            k = (k == 8) ? 0 : k + 1;
         end
         if (!scl_line && prev_scl) begin
            if (tx_mode && k < 8)       slv_sda_low = !slv_mem[tx_idx][7-k];
            else if (!tx_mode && k == 8) slv_sda_low = slv_ack;
            else                         slv_sda_low = 1'b0;
            if (stretch_arm && k == stretch_k) begin
               slv_scl_low = 1'b1; stretch_cnt = STRETCH; stretch_arm = 0;
            end
         end
         if (scl_line == prev_scl) run_len++;
         else begin
            if (prev_scl && run_len < min_hi) min_hi = run_len;
            if (!prev_scl && run_len < min_lo) min_lo = run_len;
            run_len = 1;
         end
         prev_scl = scl_line;
         prev_sda = sda_line;
      end
   end

   // ---- helpers ----
   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk); addr = a; #1; v = rdata;
   endtask

   task automatic wait_idle(output int cyc);
      logic [7:0] v;
      cyc = 0;
      do begin rd(1'b1, v); cyc++; end while (v[7] && cyc < 20000);
      if (cyc >= 20000) check(0, "R2 busy timeout", cyc, 0);
   endtask

   task automatic run_cmd(input logic [7:0] c, output int cyc);
      wr(1'b1, c);
      wait_idle(cyc);
   endtask

   function automatic logic [7:0] exp_ctrl(input logic [7:0] c, input bit stat);
      return {2'b00, c[5], stat, 1'b0, c[2:0]};
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, d, c;
      int cyc, exp_starts, exp_stops;
      void'($urandom(32'd4242));
      for (int i = 0; i < 8; i++) slv_mem[i] = '0;
      exp_starts = 0; exp_stops = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1'b0, v); check(v == 8'h00, "R1 data reset", v, 0);
      rd(1'b1, v); check(v == 8'h00, "R1 ctrl reset", v, 0);
      check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

      // R2 command without go bit
      wr(1'b1, 8'h47);
      repeat (3) @(negedge clk);
      rd(1'b1, v); check(v == 8'h00, "R2 no launch without bit7", v, 0);
      check(starts == 0, "R2 no bus activity", starts, 0);

      // R3 R5 address write with start
      slv_ack = 1;
      wr(1'b0, 8'hA4); run_cmd(8'hC2, cyc); exp_starts++;
      check(starts == exp_starts, "R5 start from idle", starts, exp_starts);
      check(last_rx == 8'hA4, "R3 byte out", last_rx, 8'hA4);
      rd(1'b1, v); check(v == 8'h02, "R1 ctrl readback", v, 8'h02);

      // R10 writes while busy ignored
      wr(1'b0, 8'h3C); wr(1'b1, 8'hC0);
      wr(1'b0, 8'h55); wr(1'b1, 8'hC5);
      wait_idle(cyc);
      check(last_rx == 8'h3C, "R10 busy data write ignored", last_rx, 8'h3C);
      rd(1'b1, v); check(v == 8'h00, "R10 busy ctrl write ignored", v, 0);
      rd(1'b0, v); check(v == 8'h3C, "R10 data reg kept", v, 8'h3C);
      check(stops == exp_stops, "R10 no stop", stops, exp_stops);
      check(scl_oe && !sda_oe, "R6 end without stop holds SCL low", {scl_oe, sda_oe}, 2'b10);

      // R8 NACK with stop
      slv_ack = 0;
      wr(1'b0, 8'h99); run_cmd(8'hC4, cyc); exp_stops++;
      rd(1'b1, v); check(v == 8'h14, "R8 nack status", v, 8'h14);
      check(stops == exp_stops, "R6 stop issued", stops, exp_stops);
      check(!scl_oe && !sda_oe, "R6 released after stop", {scl_oe, sda_oe}, 0);

      // R9 bit6 ignored
      slv_ack = 1;
      wr(1'b0, 8'hA4); run_cmd(8'h82, cyc); exp_starts++;
      check(starts == exp_starts && last_rx == 8'hA4, "R9 cmd without bit6", last_rx, 8'hA4);
      rd(1'b1, v); check(v == 8'h02, "R9 bit6 reads 0", v, 8'h02);
      wr(1'b0, 8'h10); run_cmd(8'h80, cyc);
      check(last_rx == 8'h10, "R9 data byte", last_rx, 8'h10);

      // R5 repeated start, R4 R7 reads
      slv_mem[0] = 8'h5A; slv_mem[1] = 8'hC3;
      wr(1'b0, 8'hA5); run_cmd(8'hC2, cyc); exp_starts++;
      check(starts == exp_starts, "R5 repeated start", starts, exp_starts);
      run_cmd(8'hE1, cyc);
      rd(1'b0, v); check(v == 8'h5A, "R4 read byte", v, 8'h5A);
      check(master_ack == 1'b0, "R7 master ack", master_ack, 0);
      rd(1'b1, v); check(v == 8'h21, "R8 ack status after own ack", v, 8'h21);
      run_cmd(8'hC5, cyc); exp_stops++;
      rd(1'b0, v); check(v == 8'hC3, "R4 second read", v, 8'hC3);
      check(master_ack == 1'b1, "R7 master nack", master_ack, 1);
      rd(1'b1, v); check(v == 8'h15, "R8 nack status read", v, 8'h15);
      check(stops == exp_stops, "R6 stop after read", stops, exp_stops);

      // R12 clock stretching
      wr(1'b0, 8'hA4); run_cmd(8'hC2, cyc); exp_starts++;
      stretch_arm = 1;
      wr(1'b0, 8'h6E); run_cmd(8'hC4, cyc); exp_stops++;
      check(last_rx == 8'h6E, "R12 byte intact under stretch", last_rx, 8'h6E);
      check(cyc >= STRETCH, "R12 busy spans stretch", cyc, STRETCH);

      // random mix
      for (int t = 0; t < 25; t++) begin
         int n;
         bit is_rd;
         n = 1 + int'($urandom % 3);
         is_rd = $urandom % 2;
         if (is_rd) begin
            slv_ack = 1;
            for (int i = 0; i < n; i++) slv_mem[i] = 8'($urandom);
            wr(1'b0, {7'($urandom), 1'b1}); run_cmd(8'hC2, cyc); exp_starts++;
            for (int i = 0; i < n; i++) begin
               bit last;
               last = (i == n - 1);
               c = last ? 8'hC5 : 8'hE1;
               if ($urandom % 2) c[6] = 1'b0;
               run_cmd(c, cyc);
               if (last) exp_stops++;
               rd(1'b0, v); check(v == slv_mem[i], "R4 random read", v, slv_mem[i]);
               check(master_ack == last, "R7 random ack", master_ack, last);
               rd(1'b1, v); check(v == exp_ctrl(c, last), "R8 random read status", v, exp_ctrl(c, last));
            end
         end else begin
            slv_ack = $urandom % 2;
            d = {7'($urandom), 1'b0};
            wr(1'b0, d); run_cmd(8'hC2, cyc); exp_starts++;
            check(last_rx == d, "R3 random address", last_rx, d);
            for (int i = 0; i < n; i++) begin
               slv_ack = $urandom % 2;
               d = 8'($urandom);
               c = (i == n - 1) ? 8'hC4 : 8'hC0;
               if ($urandom % 2) c[5] = 1'b1;   // R7 ack bit ignored on writes
               if ($urandom % 2) c[6] = 1'b0;
               if (i == n - 1) exp_stops++;
               wr(1'b0, d); run_cmd(c, cyc);
               check(last_rx == d, "R3 random write byte", last_rx, d);
               rd(1'b1, v); check(v == exp_ctrl(c, !slv_ack), "R8 random write status", v, exp_ctrl(c, !slv_ack));
            end
         end
      end

      check(starts == exp_starts, "R11 start count", starts, exp_starts);
      check(stops == exp_stops, "R11 stop count", stops, exp_stops);
      check(min_hi >= 2 * QDIV, "R13 min high phase", min_hi, 2 * QDIV);
      check(min_lo >= 2 * QDIV, "R13 min low phase", min_lo, 2 * QDIV);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule